// File: doc/BRIEF.md
# Soft-Stepping Amplifier Gain Sequencer

This block owns the gain code applied to an input amplifier ahead of a converter. Software writes a target code, and the block walks the applied code toward it one 0.5 dB step at a time. A step may happen only on a step tick. A tick comes from the per-sample strobe, either on every strobe or on every second strobe. Because the gain never jumps, gain changes cause no audible clicks. Codes run from 0 (0 dB) to 119 (59.5 dB).

The block comes out of reset muted. When the mute request is released, the applied code starts at 0 and climbs to the target. When mute is requested, the code descends to 0 before the mute flag rises.

There are three states:
- MUTED: the gain is held at 0 and the mute flag is high.
- TRACK: the gain follows the target.
- FADE: the gain descends toward 0.

The transitions are:
- MUTED to TRACK when the mute request is low.
- TRACK to FADE when the mute request is high.
- FADE to TRACK when the mute request drops.
- FADE to MUTED when the applied code is 0 and the mute request is still high.

Top module: `soft_gain_seq`

## Requirements
- R1: After reset, the state is MUTED, `gain_o` is 0, `muted_o` is 1, `settled_o` is 0, and the stored target is 0.
- R2: With `rate_sel_i`=0, every strobe is a step tick. On a tick, `gain_o` moves by exactly one code toward the goal, and it is visible one clock after the strobe.
- R3: With `rate_sel_i`=1, only every second strobe is a step tick. Writing a target clears this pacing, so the first step after a write comes on the second strobe after the write.
- R4: `gain_o` stops exactly at the target, with no overshoot. Further strobes then leave it unchanged.
- R5: If a new target is written during a ramp, the ramp continues from the current code and reverses direction if the new target lies behind.
- R6: A written target above 119 is stored as 119.
- R7: `settled_o` is 1 only in TRACK and only when `gain_o` equals the stored target.
- R8: Releasing mute moves MUTED to TRACK on the next clock. `gain_o` starts from 0 and ramps up to the target.
- R9: Requesting mute moves the block to FADE. The gain then steps down to 0, and `muted_o` rises one clock after `gain_o` reaches 0.
- R10: `gain_o` changes only in the clock after a strobe. It changes by at most one code per clock and never exceeds 119.
- R11: A strobe in the same cycle as a target write (`target_we_i`=1) is not a step tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| target_i | input | 7 | Target gain code, in 0.5 dB units |
| target_we_i | input | 1 | Target write pulse |
| mute_req_i | input | 1 | Mute request (level) |
| rate_sel_i | input | 1 | 0: step on every strobe; 1: step on every second strobe |
| strobe_i | input | 1 | One-cycle pulse per converter output sample |
| gain_o | output | 7 | Applied gain code |
| muted_o | output | 1 | High in MUTED |
| settled_o | output | 1 | Applied code equals target and not muted |

## Verification
The bench sweeps targets across the full range at both step rates. After every strobe it compares the applied code with an arithmetic model. A stepper that overshoots, or that skips a code, shows a mismatch on the first wrong strobe. A divider that is not restarted by a write steps one strobe early after the write.

Out-of-range targets are checked for clamping; a design without the clamp would ramp past 119. A write issued together with a strobe is checked to cause no step.

Mid-ramp reversal is checked; a design that holds the ramp direction would run away from the new target. The bench also checks that the mute flag rises only after the code is back at 0; a design that mutes at once would cut the gain with a click.

// File: rtl/soft_gain_pkg.sv
package soft_gain_pkg;
    typedef enum logic [1:0] {
        ST_MUTED = 2'd0,
        ST_TRACK = 2'd1,
        ST_FADE  = 2'd2
    } sg_state_e;
endpackage

// File: rtl/sg_step_pacer.sv
module sg_step_pacer (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    input  logic rate_sel_i,
    input  logic restart_i,
    output logic tick_o
);
    logic half_q;

    // A strobe coinciding with a restart never ticks.
    assign tick_o = strobe_i && !restart_i && (!rate_sel_i || half_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q <= 1'b0;
        end else if (restart_i) begin
            half_q <= 1'b0;
        end else if (strobe_i) begin
            half_q <= rate_sel_i ? !half_q : 1'b0;
        end
    end
endmodule

// File: rtl/sg_gain_stepper.sv
module sg_gain_stepper #(
    parameter int GAIN_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              step_i,
    input  logic [GAIN_W-1:0] goal_i,
    output logic [GAIN_W-1:0] gain_o,
    output logic              at_goal_o
);
    logic [GAIN_W-1:0] gain_q;

    assign gain_o    = gain_q;
    assign at_goal_o = (gain_q == goal_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gain_q <= '0;
        end else if (clear_i) begin
            gain_q <= '0;
        end else if (step_i && !at_goal_o) begin
            if (gain_q < goal_i) begin
                gain_q <= gain_q + 1'b1;
            end else begin
                gain_q <= gain_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/soft_gain_seq.sv
module soft_gain_seq
    import soft_gain_pkg::*;
#(
    parameter int GAIN_W   = 7,
    parameter int GAIN_MAX = 119
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GAIN_W-1:0] target_i,
    input  logic              target_we_i,
    input  logic              mute_req_i,
    input  logic              rate_sel_i,
    input  logic              strobe_i,
    output logic [GAIN_W-1:0] gain_o,
    output logic              muted_o,
    output logic              settled_o
);
    localparam logic [GAIN_W-1:0] CODE_TOP = GAIN_W'(GAIN_MAX);

    sg_state_e         state_q, state_d;
    logic [GAIN_W-1:0] tgt_q;
    logic [GAIN_W-1:0] goal;
    logic              tick;
    logic              at_goal;
    logic              clear;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_q <= '0;
        end else if (target_we_i) begin
            tgt_q <= (target_i > CODE_TOP) ? CODE_TOP : target_i;
        end
    end

    sg_step_pacer u_pacer (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe_i  (strobe_i),
        .rate_sel_i(rate_sel_i),
        .restart_i (target_we_i),
        .tick_o    (tick)
    );

    sg_gain_stepper #(.GAIN_W(GAIN_W)) u_stepper (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (clear),
        .step_i   (tick),
        .goal_i   (goal),
        .gain_o   (gain_o),
        .at_goal_o(at_goal)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_MUTED;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_MUTED: if (!mute_req_i) state_d = ST_TRACK;
            ST_TRACK: if (mute_req_i)  state_d = ST_FADE;
            ST_FADE: begin
                if (!mute_req_i)            state_d = ST_TRACK;
                else if (gain_o == '0)      state_d = ST_MUTED;
            end
            default: state_d = ST_MUTED;
        endcase
    end

    // Outputs and stepper control
    always_comb begin
        goal      = '0;
        clear     = 1'b0;
        muted_o   = 1'b0;
        settled_o = 1'b0;
        unique case (state_q)
            ST_MUTED: begin
                clear   = 1'b1;
                muted_o = 1'b1;
            end
            ST_TRACK: begin
                goal      = tgt_q;
                settled_o = at_goal;
            end
            ST_FADE: goal = '0;
            default: clear = 1'b1;
        endcase
    end
endmodule

// File: rtl/sg_checker.sv
module sg_checker #(
    parameter int GAIN_W   = 7,
    parameter int GAIN_MAX = 119
) (
    input logic              clk,
    input logic              rst_n,
    input logic              strobe_i,
    input logic [GAIN_W-1:0] gain_o,
    input logic              muted_o,
    input logic              settled_o
);
    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_o != $past(gain_o)) |-> ((gain_o == $past(gain_o) + 1'b1) || (gain_o + 1'b1 == $past(gain_o)))); // R10
    AST_STROBE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_o != $past(gain_o)) |-> $past(strobe_i)); // R10
    AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(gain_o) <= GAIN_MAX)); // R6
    AST_MUTE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        muted_o |-> (gain_o == '0)); // R9
    AST_SETTLED_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        settled_o |-> !muted_o); // R7
endmodule

bind soft_gain_seq sg_checker #(.GAIN_W(GAIN_W), .GAIN_MAX(GAIN_MAX)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_i (strobe_i),
    .gain_o   (gain_o),
    .muted_o  (muted_o),
    .settled_o(settled_o)
);

// File: tb/sim_soft_gain_seq.sv
module sim_soft_gain_seq;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] target_i = '0;
    logic       target_we_i = 1'b0;
    logic       mute_req_i = 1'b1;
    logic       rate_sel_i = 1'b0;
    logic       strobe_i = 1'b0;
    logic [6:0] gain_o;
    logic       muted_o;
    logic       settled_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // model
    int  m_gain = 0;
    int  m_tgt = 0;
    bit  m_phase = 1'b0;
    bit  m_fade = 1'b0;
    bit  m_muted = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    soft_gain_seq u0 (
        .clk(clk), .rst_n(rst_n), .target_i(target_i), .target_we_i(target_we_i),
        .mute_req_i(mute_req_i), .rate_sel_i(rate_sel_i), .strobe_i(strobe_i),
        .gain_o(gain_o), .muted_o(muted_o), .settled_o(settled_o)
    );

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic check_out(string tag);
        check(tag, "gain", int'(gain_o), m_gain);
        check(tag, "settled", int'(settled_o), (!m_fade && !m_muted && m_gain == m_tgt) ? 1 : 0);
    endtask

    task automatic strobe(string tag);
        bit tick;
        @(negedge clk) strobe_i = 1'b1;
        @(negedge clk) strobe_i = 1'b0;
        tick = !rate_sel_i || m_phase;
        m_phase = rate_sel_i ? !m_phase : 1'b0;
        if (tick && !m_muted) begin
            int goal = m_fade ? 0 : m_tgt;
            if (m_gain < goal) m_gain++;
            else if (m_gain > goal) m_gain--;
        end
        check_out(tag);
    endtask

    task automatic write_tgt(int t);
        @(negedge clk) begin target_i = 7'(t); target_we_i = 1'b1; end
        @(negedge clk) target_we_i = 1'b0;
        m_tgt = (t > 119) ? 119 : t;
        m_phase = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "gain", int'(gain_o), 0);
        check("R1", "muted", int'(muted_o), 1);
        check("R1", "settled", int'(settled_o), 0);
        // muted: strobes leave gain at zero
        strobe("R1");

        // R8 leave mute with target 0 -> settled at 0
        @(negedge clk) mute_req_i = 1'b0;
        @(negedge clk);
        m_muted = 1'b0;
        check("R8", "muted", int'(muted_o), 0);
        check_out("R7");

        // R2 rate 0 ramp up, R4 stop exactly
        write_tgt(10);
        check_out("R7");
        for (int i = 0; i < 13; i++) strobe("R2");
        check_out("R4");

        // R10 idle cycles: no change without strobe
        repeat (5) @(negedge clk);
        check_out("R10");

        // R5 reverse mid ramp
        write_tgt(40);
        for (int i = 0; i < 6; i++) strobe("R5");
        write_tgt(3);
        for (int i = 0; i < 16; i++) strobe("R5");
        check_out("R4");

        // R11 strobe coinciding with a write does not step
        @(negedge clk) begin target_i = 7'd50; target_we_i = 1'b1; strobe_i = 1'b1; end
        @(negedge clk) begin target_we_i = 1'b0; strobe_i = 1'b0; end
        m_tgt = 50; m_phase = 1'b0;
        check_out("R11");

        // R3 rate 1: first step on second strobe after a write
        rate_sel_i = 1'b1;
        write_tgt(20);
        strobe("R3");
        check("R3", "gain after first strobe", int'(gain_o), 3);
        strobe("R3");
        check("R3", "gain after second strobe", int'(gain_o), 4);
        for (int i = 0; i < 40; i++) strobe("R3");

        // R6 clamp
        rate_sel_i = 1'b0;
        write_tgt(127);
        while (m_gain != m_tgt) strobe("R6");
        for (int i = 0; i < 3; i++) strobe("R6");
        check("R6", "clamped gain", int'(gain_o), 119);

        // R9 enter mute: fade then mute flag
        @(negedge clk) mute_req_i = 1'b1;
        m_fade = 1'b1;
        @(negedge clk);
        check_out("R9");
        check("R9", "muted during fade", int'(muted_o), 0);
        while (m_gain > 0) strobe("R9");
        @(negedge clk);
        m_muted = 1'b1; m_fade = 1'b0;
        check("R9", "muted after fade", int'(muted_o), 1);
        check_out("R9");

        // R8 leave mute: ramp up from zero
        @(negedge clk) mute_req_i = 1'b0;
        @(negedge clk);
        m_muted = 1'b0;
        check_out("R8");
        for (int i = 0; i < 8; i++) strobe("R8");

        // R2 R3 sweep targets at both rates
        for (int r = 0; r < 2; r++) begin
            rate_sel_i = r[0];
            for (int t = 0; t <= 119; t += 17) begin
                write_tgt(t);
                while (m_gain != m_tgt) strobe(r == 0 ? "R2" : "R3");
                strobe("R4");
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule